// File: doc/BRIEF.md
# Dual-Register Bus Transceiver

This block sits between two parallel data buses, called A and B, and moves a word from one to the other in one direction at a time. Each bus has its own holding register, and each register has its own capture clock. For each direction a select input chooses the source. The source is either the word on the input bus at that moment (pass-through) or the word last captured in that side's register (replay). An active-low enable and a direction input decide which bus, if either, the block drives.

The two bus pins are split into an input, an output value and an output enable for each side. When a side's enable is low, its output value is held at zero. The capture path is never gated. A register takes the word from its own bus on every rising edge of its clock, whatever the enable and direction are doing. Software-free system logic can therefore park a word while both buses are isolated and replay it later. An asynchronous active-low reset clears both registers.

Top module: `dual_store_xcvr`

## Requirements
- R1: The A register loads `aIn` on each rising edge of `clkAtoB`, and the B register loads `bIn` on each rising edge of `clkBtoA`, for every value of `outEnN`, `dirAtoB`, `selAB` and `selBA`.
- R2: While `outEnN` is 1, both `aOe` and `bOe` are 0.
- R3: While `outEnN` is 0 and `dirAtoB` is 1, `bOe` is 1 and `aOe` is 0.
- R4: While `outEnN` is 0 and `dirAtoB` is 0, `aOe` is 1 and `bOe` is 0.
- R5: With `bOe` at 1 and `selAB` at 0, `bOut` equals the present `aIn`, and pulses on either capture clock do not alter that relation.
- R6: With `bOe` at 1 and `selAB` at 1, `bOut` equals the A register contents.
- R7: With `aOe` at 1 and `selBA` at 0, `aOut` equals the present `bIn`, and pulses on either capture clock do not alter that relation.
- R8: With `aOe` at 1 and `selBA` at 1, `aOut` equals the B register contents.
- R9: In replay mode the driven output changes only on a rising edge of the source side's clock. A change on the source input bus alone leaves it unchanged, and so does an edge on the other clock.
- R10: A low level on `rstN` clears both registers to zero at once, without waiting for a clock edge.
- R11: Whenever a side's output enable is 0, that side's output value is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous reset, active low; clears both registers |
| clkAtoB | input | 1 | Capture clock of the A register (rising edge) |
| clkBtoA | input | 1 | Capture clock of the B register (rising edge) |
| outEnN | input | 1 | Output enable, active low; 1 isolates both buses |
| dirAtoB | input | 1 | 1: drive bus B from the A side; 0: drive bus A from the B side |
| selAB | input | 1 | Source for B: 0 live A input, 1 A register |
| selBA | input | 1 | Source for A: 0 live B input, 1 B register |
| aIn | input | W (8) | Word present on bus A |
| aOut | output | W (8) | Word driven onto bus A (zero when not enabled) |
| aOe | output | 1 | Drive enable for bus A |
| bIn | input | W (8) | Word present on bus B |
| bOut | output | W (8) | Word driven onto bus B (zero when not enabled) |
| bOe | output | 1 | Drive enable for bus B |

## Verification
The hardest case to reach from the ports is a capture that happens while nothing is visible: the register loads with both buses isolated, or while its own side is the one being driven. The effect of that capture shows up only after the controls are moved to replay it. The stimulus pulses a capture clock with the enable high and checks that both outputs stay zero. It then switches to replay in that direction without any further clock and checks that the parked word appears. A second scenario holds replay mode and changes the source bus and the opposite clock. It shows the output staying put until the source clock pulses.

// File: rtl/dual_store_xcvr_pkg.sv
`timescale 1ns/1ps
package dual_store_xcvr_pkg;

  // Strobes handed from the mode decoder to the datapath.
  typedef struct packed {
    logic driveA;     // bus A is driven
    logic driveB;     // bus B is driven
    logic replayToA;  // A output takes the B register
    logic replayToB;  // B output takes the A register
  } xcvr_strobe_t;

  localparam int unsigned SIDE_A = 0;
  localparam int unsigned SIDE_B = 1;
  localparam int unsigned NUM_SIDES = 2;

endpackage

// File: rtl/dual_store_xcvr_hold.sv
`timescale 1ns/1ps
module dual_store_xcvr_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Capture is unconditional: every rising edge loads the bus word.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= d;
  end

endmodule

// File: rtl/dual_store_xcvr_ctrl.sv
`timescale 1ns/1ps
module dual_store_xcvr_ctrl
  import dual_store_xcvr_pkg::*;
(
  input  logic         outEnN,
  input  logic         dirAtoB,
  input  logic         selAB,
  input  logic         selBA,
  output xcvr_strobe_t strobe
);

  logic enabled;

  always_comb begin
    enabled          = !outEnN;
    strobe.driveB    = enabled && dirAtoB;
    strobe.driveA    = enabled && !dirAtoB;
    strobe.replayToB = selAB;
    strobe.replayToA = selBA;
  end

endmodule

// File: rtl/dual_store_xcvr_dp.sv
`timescale 1ns/1ps
module dual_store_xcvr_dp
  import dual_store_xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         rstN,
  input  logic         clkAtoB,
  input  logic         clkBtoA,
  input  xcvr_strobe_t strobe,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] aOut,
  output logic [W-1:0] bOut
);

  logic [NUM_SIDES-1:0] capClk;
  logic [W-1:0]         busIn [NUM_SIDES];
  logic [W-1:0]         held  [NUM_SIDES];
  logic [W-1:0]         toA;
  logic [W-1:0]         toB;

  assign capClk[SIDE_A] = clkAtoB;
  assign capClk[SIDE_B] = clkBtoA;
  assign busIn[SIDE_A]  = aIn;
  assign busIn[SIDE_B]  = bIn;

  // One holding register per side, each on its own clock.
  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    dual_store_xcvr_hold #(.W(W)) hold_i (
      .clk  (capClk[s]),
      .rstN (rstN),
      .d    (busIn[s]),
      .q    (held[s])
    );
  end

  // Source selection per direction, then zero when not driven.
  always_comb begin
    toB  = strobe.replayToB ? held[SIDE_A] : aIn;
    toA  = strobe.replayToA ? held[SIDE_B] : bIn;
    bOut = strobe.driveB ? toB : '0;
    aOut = strobe.driveA ? toA : '0;
  end

endmodule

// File: rtl/dual_store_xcvr.sv
`timescale 1ns/1ps
module dual_store_xcvr
  import dual_store_xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         rstN,
  input  logic         clkAtoB,
  input  logic         clkBtoA,
  input  logic         outEnN,
  input  logic         dirAtoB,
  input  logic         selAB,
  input  logic         selBA,
  input  logic [W-1:0] aIn,
  output logic [W-1:0] aOut,
  output logic         aOe,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] bOut,
  output logic         bOe
);

  xcvr_strobe_t strobe;

  dual_store_xcvr_ctrl ctrl_i (
    .outEnN  (outEnN),
    .dirAtoB (dirAtoB),
    .selAB   (selAB),
    .selBA   (selBA),
    .strobe  (strobe)
  );

  dual_store_xcvr_dp #(.W(W)) dp_i (
    .rstN    (rstN),
    .clkAtoB (clkAtoB),
    .clkBtoA (clkBtoA),
    .strobe  (strobe),
    .aIn     (aIn),
    .bIn     (bIn),
    .aOut    (aOut),
    .bOut    (bOut)
  );

  assign aOe = strobe.driveA;
  assign bOe = strobe.driveB;

endmodule

// File: rtl/dual_store_xcvr_chk.sv
`timescale 1ns/1ps
module dual_store_xcvr_chk #(
  parameter int unsigned W = 8
) (
  input logic         rstN,
  input logic         clkAtoB,
  input logic         clkBtoA,
  input logic         outEnN,
  input logic         dirAtoB,
  input logic         selAB,
  input logic         selBA,
  input logic [W-1:0] aIn,
  input logic [W-1:0] aOut,
  input logic         aOe,
  input logic [W-1:0] bIn,
  input logic [W-1:0] bOut,
  input logic         bOe
);

  // Set once a capture edge has occurred since reset, so $past is meaningful.
  logic seenA;
  logic seenB;

  always_ff @(posedge clkAtoB or negedge rstN) begin
    if (!rstN) seenA <= 1'b0;
    else       seenA <= 1'b1;
  end

  always_ff @(posedge clkBtoA or negedge rstN) begin
    if (!rstN) seenB <= 1'b0;
    else       seenB <= 1'b1;
  end

  // R2
  isolate_chk: assert property (@(posedge clkAtoB) disable iff (!rstN)
    outEnN |-> (!aOe && !bOe));

  // R3
  drive_b_chk: assert property (@(posedge clkAtoB) disable iff (!rstN)
    (!outEnN && dirAtoB) |-> (bOe && !aOe));

  // R4
  drive_a_chk: assert property (@(posedge clkBtoA) disable iff (!rstN)
    (!outEnN && !dirAtoB) |-> (aOe && !bOe));

  // R5
  pass_to_b_chk: assert property (@(posedge clkAtoB) disable iff (!rstN)
    (bOe && !selAB) |-> (bOut == aIn));

  // R7
  pass_to_a_chk: assert property (@(posedge clkBtoA) disable iff (!rstN)
    (aOe && !selBA) |-> (aOut == bIn));

  // R6
  replay_to_b_chk: assert property (@(posedge clkAtoB) disable iff (!rstN)
    (seenA && bOe && selAB) |-> (bOut == $past(aIn)));

  // R8
  replay_to_a_chk: assert property (@(posedge clkBtoA) disable iff (!rstN)
    (seenB && aOe && selBA) |-> (aOut == $past(bIn)));

  // R11
  idle_zero_chk: assert property (@(posedge clkAtoB) disable iff (!rstN)
    ((!aOe -> (aOut == '0)) && (!bOe -> (bOut == '0))));

endmodule

bind dual_store_xcvr dual_store_xcvr_chk #(.W(W)) chk_i (
  .rstN    (rstN),
  .clkAtoB (clkAtoB),
  .clkBtoA (clkBtoA),
  .outEnN  (outEnN),
  .dirAtoB (dirAtoB),
  .selAB   (selAB),
  .selBA   (selBA),
  .aIn     (aIn),
  .aOut    (aOut),
  .aOe     (aOe),
  .bIn     (bIn),
  .bOut    (bOut),
  .bOe     (bOe)
);

// File: tb/dual_store_xcvr_tb_top.sv
`timescale 1ns/1ps
module dual_store_xcvr_tb_top;

  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic         clkAtoB, clkBtoA;
  logic         outEnN, dirAtoB, selAB, selBA;
  logic [W-1:0] aIn, bIn;
  logic [W-1:0] aOut, bOut;
  logic         aOe, bOe;

  int compared   = 0;
  int mismatched = 0;
  int cyc        = 0;

  // Bench-side model of the two holding registers.
  logic [W-1:0] mA, mB;

  always #2 clk = ~clk;  // 250 MHz

  dual_store_xcvr #(.W(W)) dut_i (
    .rstN(rstN), .clkAtoB(clkAtoB), .clkBtoA(clkBtoA),
    .outEnN(outEnN), .dirAtoB(dirAtoB), .selAB(selAB), .selBA(selBA),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        compared++;
        mismatched++;
        $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
        finishRun();
      end
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pulseA();
    #1 clkAtoB = 1'b1; mA = aIn;
    #2 clkAtoB = 1'b0;
    #1;
  endtask

  task automatic pulseB();
    #1 clkBtoA = 1'b1; mB = bIn;
    #2 clkBtoA = 1'b0;
    #1;
  endtask

  // Full comparison of all outputs against the model (R2-R8, R11).
  task automatic chkAll(input string req);
    logic         eA, eB;
    logic [W-1:0] oA, oB;
    #1;
    eA = !outEnN && !dirAtoB;
    eB = !outEnN && dirAtoB;
    oA = eA ? (selBA ? mB : bIn) : '0;
    oB = eB ? (selAB ? mA : aIn) : '0;
    chk({req, " aOe"},  {7'b0, aOe}, {7'b0, eA});
    chk({req, " bOe"},  {7'b0, bOe}, {7'b0, eB});
    chk({req, " aOut"}, aOut, oA);
    chk({req, " bOut"}, bOut, oB);
  endtask

  task automatic doReset();
    rstN = 1'b0; clkAtoB = 1'b0; clkBtoA = 1'b0;
    outEnN = 1'b0; dirAtoB = 1'b1; selAB = 1'b1; selBA = 1'b1;
    aIn = 8'h77; bIn = 8'h88;
    mA = '0; mB = '0;
    #5;
    chk("R10 reset A reg via B", bOut, 8'h00);
    dirAtoB = 1'b0;
    #1 chk("R10 reset B reg via A", aOut, 8'h00);
    rstN = 1'b1;
    #2;
  endtask

  task automatic testCombos();
    aIn = 8'h3C; bIn = 8'hC3;
    pulseA(); pulseB();
    for (int c = 0; c < 16; c++) begin
      {outEnN, dirAtoB, selAB, selBA} = c[3:0];
      aIn = 8'h5A ^ 8'(c * 17);
      bIn = 8'hA5 ^ 8'(c * 29);
      chkAll("R2/R3/R4/R5/R6/R7/R8/R11 combo");
    end
  endtask

  task automatic testIsolatedCapture();
    outEnN = 1'b1; dirAtoB = 1'b1; selAB = 1'b1; selBA = 1'b1;
    aIn = 8'hE1; bIn = 8'h1E;
    pulseA(); pulseB();
    #1;
    chk("R2 isolated aOut", aOut, 8'h00);
    chk("R2 isolated bOut", bOut, 8'h00);
    outEnN = 1'b0;
    #1 chk("R1 parked A word replayed to B", bOut, 8'hE1);
    dirAtoB = 1'b0;
    #1 chk("R1 parked B word replayed to A", aOut, 8'h1E);
    // Capture into A while bus A is the driven side.
    aIn = 8'h42;
    pulseA();
    dirAtoB = 1'b1;
    #1 chk("R1 A captures while A driven", bOut, 8'h42);
  endtask

  task automatic testReplayEdge();
    outEnN = 1'b0; dirAtoB = 1'b1; selAB = 1'b1;
    aIn = 8'h10; pulseA();
    aIn = 8'h99;
    #1 chk("R9 B holds after aIn change", bOut, 8'h10);
    bIn = 8'h66; pulseB();
    #1 chk("R9 B holds after far clock", bOut, 8'h10);
    pulseA();
    chk("R6 B updates on source edge", bOut, 8'h99);
    dirAtoB = 1'b0; selBA = 1'b1;
    bIn = 8'h07; pulseB();
    bIn = 8'hF0;
    #1 chk("R9 A holds after bIn change", aOut, 8'h07);
    pulseA();
    #1 chk("R9 A holds after far clock", aOut, 8'h07);
    pulseB();
    chk("R8 A updates on source edge", aOut, 8'hF0);
  endtask

  task automatic testPassClocks();
    outEnN = 1'b0; dirAtoB = 1'b1; selAB = 1'b0;
    aIn = 8'h2B; pulseA();
    aIn = 8'hD4;
    #1 chk("R5 B follows live A", bOut, 8'hD4);
    pulseA(); pulseB();
    chk("R5 B live after clocks", bOut, 8'hD4);
    dirAtoB = 1'b0; selBA = 1'b0;
    bIn = 8'h81; pulseB();
    bIn = 8'h18;
    #1 chk("R7 A follows live B", aOut, 8'h18);
    pulseA(); pulseB();
    chk("R7 A live after clocks", aOut, 8'h18);
  endtask

  task automatic testAsyncReset();
    outEnN = 1'b0; dirAtoB = 1'b1; selAB = 1'b1; selBA = 1'b1;
    aIn = 8'hBE; bIn = 8'hEF;
    pulseA(); pulseB();
    #1 chk("R6 before reset", bOut, 8'hBE);
    rstN = 1'b0; mA = '0; mB = '0;
    #1 chk("R10 async clear A", bOut, 8'h00);
    dirAtoB = 1'b0;
    #1 chk("R10 async clear B", aOut, 8'h00);
    rstN = 1'b1;
    #2;
  endtask

  initial begin
    doReset();
    testCombos();
    testIsolatedCapture();
    testReplayEdge();
    testPassClocks();
    testAsyncReset();
    testCombos();
    finishRun();
  end

endmodule